// File: doc/BRIEF.md
# ADC Conversion Start Controller

This block sequences conversions for two analog-to-digital converter channels from the control side. Each channel picks one trigger among a software start strobe, two timer overflow pulses and a rising edge on its own external start pin. The second channel can also follow the first channel's software start strobe. The converter clock for each channel is the system clock divided by a programmable factor from 1 to 16. An optional tracking window of three converter clocks can be placed after the trigger and before the conversion.

While a conversion runs, the channel's busy output is high. When the conversion finishes, busy drops and a sticky completion flag is set. The flag drives an interrupt request if that channel's interrupt enable is set. The analog core is modelled by a sixteen-clock conversion counter. On completion it latches a 16-bit data word whose top bit is the channel number and whose low 15 bits count the conversions that channel has completed. Software typically clears the flag, issues a start, polls the flag and then reads the result.

Top module: `adc_start_seq`

## Requirements
- R1: After reset, busy, flag, irq and both results are 0, and tracking equals the channel enable.
- R2: A converter clock lasts div+1 system clocks (div field 0..15). A conversion without a tracking window keeps busy high for 16*(div+1) cycles. With the window, busy stays high for 19*(div+1) cycles.
- R3: Channel 0 start select: 0 = sw_start[0] pulse, 1 = tmr3_ovf, 2 = rising edge of ext_start[0], 3 = tmr2_ovf. Sources that are not selected have no effect.
- R4: Channel 1 start select: 0..3 as channel 0 but using sw_start[1] and ext_start[1]; 4 = sw_start[0]; 5..7 = no source, so the channel never starts.
- R5: An external start pin passes through two synchronizing flops. A rising edge set up before edge A starts the channel at edge A+2, so busy reads 1 after the third edge. A pin held high starts only one conversion.
- R6: When track_mode is 1, tracking stays high during the first 3*(div+1) busy cycles and then falls until completion. When track_mode is 0, tracking is low for the whole time busy is high. While the channel is enabled and idle, tracking is high.
- R7: On the edge where busy falls on completion, flag is set. irq equals flag AND int_en.
- R8: The flag stays set until a flag_clr pulse.
- R9: On completion, result holds {channel number, 15-bit count of completed conversions of that channel}, and it holds that value until the next completion.
- R10: A trigger that arrives while the channel is busy is ignored.
- R11: When en is low, busy is 0 from the next edge and tracking is 0. A conversion in progress is dropped without setting flag or changing result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| en | input | 2 | Channel enables |
| mode0 | input | 2 | Channel 0 start select |
| mode1 | input | 3 | Channel 1 start select |
| div0 | input | 4 | Channel 0 clock divide minus one |
| div1 | input | 4 | Channel 1 clock divide minus one |
| track_mode | input | 2 | Insert tracking window per channel |
| int_en | input | 2 | Interrupt enables |
| sw_start | input | 2 | Software start strobes (write 1 to busy) |
| flag_clr | input | 2 | Flag clear strobes (write 0 to flag) |
| tmr3_ovf | input | 1 | Timer 3 overflow pulse |
| tmr2_ovf | input | 1 | Timer 2 overflow pulse |
| ext_start | input | 2 | Asynchronous external start pins |
| busy | output | 2 | Conversion in progress |
| flag | output | 2 | Sticky completion flags |
| irq | output | 2 | Interrupt requests |
| tracking | output | 2 | Input sampling switch closed |
| result0 | output | 16 | Channel 0 data word |
| result1 | output | 16 | Channel 1 data word |

## Verification
On every cycle, the assertions check the following: a disabled channel goes idle, the flag rises only together with a completing busy fall, every completion sets the flag, and channel 1 stays idle under a reserved start select. The bench scenarios cover what the properties cannot: exact busy lengths across several divide and tracking settings, selection of each source, the synchronizer latency, the tracking window's position, and that repeated triggers do not restart a conversion. They also check the result word's running count and that an aborted conversion leaves no trace.

// File: rtl/adc_start_seq.sv
module adc_start_seq #(
  parameter int DIV_W      = 4,
  parameter int TRACK_CLKS = 3,
  parameter int CONV_CLKS  = 16,
  parameter int DATA_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        en,
  input  logic [1:0]        mode0,
  input  logic [2:0]        mode1,
  input  logic [DIV_W-1:0]  div0,
  input  logic [DIV_W-1:0]  div1,
  input  logic [1:0]        track_mode,
  input  logic [1:0]        int_en,
  input  logic [1:0]        sw_start,
  input  logic [1:0]        flag_clr,
  input  logic              tmr3_ovf,
  input  logic              tmr2_ovf,
  input  logic [1:0]        ext_start,
  output logic [1:0]        busy,
  output logic [1:0]        flag,
  output logic [1:0]        irq,
  output logic [1:0]        tracking,
  output logic [DATA_W-1:0] result0,
  output logic [DATA_W-1:0] result1
);
  localparam int LONGEST = (CONV_CLKS > TRACK_CLKS) ? CONV_CLKS : TRACK_CLKS;
  localparam int CNT_W = $clog2(LONGEST) + 1;
  localparam logic [CNT_W-1:0] TRK_LAST  = CNT_W'(TRACK_CLKS - 1);
  localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_CLKS - 1);

  logic [1:0] ext_s1, ext_s2, ext_s3;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {ext_s1, ext_s2, ext_s3} <= '0;
    else begin
      ext_s1 <= ext_start;
      ext_s2 <= ext_s1;
      ext_s3 <= ext_s2;
    end
  wire [1:0] ext_rise = ext_s2 & ~ext_s3;

  logic [1:0] trig;
  always_comb begin
    case (mode0)
      2'd0:    trig[0] = sw_start[0];
      2'd1:    trig[0] = tmr3_ovf;
      2'd2:    trig[0] = ext_rise[0];
      default: trig[0] = tmr2_ovf;
    endcase
    case (mode1)
      3'd0:    trig[1] = sw_start[1];
      3'd1:    trig[1] = tmr3_ovf;
      3'd2:    trig[1] = ext_rise[1];
      3'd3:    trig[1] = tmr2_ovf;
      3'd4:    trig[1] = sw_start[0];
      default: trig[1] = 1'b0;
    endcase
  end

  logic [1:0][DIV_W-1:0]  div_sel;
  logic [1:0][DATA_W-1:0] res_q;
  assign div_sel = {div1, div0};

  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic [DIV_W-1:0]  pre;
    logic [CNT_W-1:0]  cnt;
    logic              busy_r, flag_r, in_trk;
    logic [DATA_W-2:0] seq;
    logic [DATA_W-1:0] res;
    wire tick = (pre == div_sel[c]);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        busy_r <= 1'b0; flag_r <= 1'b0; in_trk <= 1'b0;
        pre <= '0; cnt <= '0; seq <= '0; res <= '0;
      end else begin
        if (flag_clr[c]) flag_r <= 1'b0;
        if (!en[c]) begin
          busy_r <= 1'b0;
          in_trk <= 1'b0;
        end else if (!busy_r) begin
          if (trig[c]) begin
            busy_r <= 1'b1;
            in_trk <= track_mode[c];
            pre    <= '0;
            cnt    <= '0;
          end
        end else if (!tick) begin
          pre <= pre + 1'b1;
        end else begin
          pre <= '0;
          if (in_trk) begin
            if (cnt == TRK_LAST) begin
              in_trk <= 1'b0;
              cnt    <= '0;
            end else cnt <= cnt + 1'b1;
          end else if (cnt == CONV_LAST) begin
            busy_r <= 1'b0;
            flag_r <= 1'b1;
            seq    <= seq + 1'b1;
            res    <= {1'(c), seq + 1'b1};
          end else cnt <= cnt + 1'b1;
        end
      end

    assign busy[c]     = busy_r;
    assign flag[c]     = flag_r;
    assign irq[c]      = flag_r & int_en[c];
    assign tracking[c] = en[c] & (~busy_r | in_trk);
    assign res_q[c]    = res;
  end

  assign result0 = res_q[0];
  assign result1 = res_q[1];
endmodule

module adc_start_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] en,
  input logic [2:0] mode1,
  input logic [1:0] busy,
  input logic [1:0] flag
);
  // R11
  off_idle0_chk: assert property (@(posedge clk) disable iff (!rst_n) !en[0] |=> !busy[0]);
  // R11
  off_idle1_chk: assert property (@(posedge clk) disable iff (!rst_n) !en[1] |=> !busy[1]);
  // R7
  done_flag0_chk: assert property (@(posedge clk) disable iff (!rst_n) ($fell(busy[0]) && en[0]) |-> flag[0]);
  // R7
  done_flag1_chk: assert property (@(posedge clk) disable iff (!rst_n) ($fell(busy[1]) && en[1]) |-> flag[1]);
  // R11
  flag_src0_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(flag[0]) |-> $fell(busy[0]));
  // R11
  flag_src1_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(flag[1]) |-> $fell(busy[1]));
  // R4
  no_src1_chk: assert property (@(posedge clk) disable iff (!rst_n) (mode1 > 3'd4 && !busy[1]) |=> !busy[1]);
endmodule

bind adc_start_seq adc_start_seq_chk u_chk (.*);

// File: tb/sim_adc_start_seq.sv
module sim_adc_start_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [1:0] en = 0, mode0 = 0, track_mode = 0, int_en = 0, sw_start = 0, flag_clr = 0, ext_start = 0;
  logic [2:0] mode1 = 0;
  logic [3:0] div0 = 0, div1 = 0;
  logic tmr3_ovf = 0, tmr2_ovf = 0;
  logic [1:0] busy, flag, irq, tracking;
  logic [15:0] result0, result1;

  adc_start_seq u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { int len; logic [15:0] res; bit abort; } item_t;
  item_t q0[$], q1[$];
  int tests = 0, fails = 0, cyc = 0;
  int done_cnt [2] = '{0, 0};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_conv(input int c, input int dv, input bit trk);
    item_t it;
    done_cnt[c]++;
    it.len = (trk ? 19 : 16) * (dv + 1);
    it.res = {c[0], 15'(done_cnt[c])};
    it.abort = 0;
    if (c == 0) q0.push_back(it); else q1.push_back(it);
  endtask

  task automatic expect_abort(input int c);
    item_t it;
    it.len = 0; it.res = 0; it.abort = 1;
    if (c == 0) q0.push_back(it); else q1.push_back(it);
  endtask

  task automatic pulse_sw(input logic [1:0] m);
    @(negedge clk) sw_start = m;
    @(negedge clk) sw_start = 0;
  endtask

  task automatic pulse_tmr(input bit t3);
    @(negedge clk) if (t3) tmr3_ovf = 1; else tmr2_ovf = 1;
    @(negedge clk) begin tmr3_ovf = 0; tmr2_ovf = 0; end
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // scoreboard monitor
  int run_len [2] = '{0, 0};
  logic [1:0] busy_prev = 0;
  always @(negedge clk) if (rst_n) begin
    for (int c = 0; c < 2; c++) begin
      if (busy[c]) run_len[c]++;
      else if (busy_prev[c]) begin
        item_t it;
        if ((c == 0 ? q0.size() : q1.size()) == 0) chk(0, "R10 unexpected conversion", 1, 0);
        else begin
          it = (c == 0) ? q0.pop_front() : q1.pop_front();
          if (it.abort) chk(flag[c] == 0, "R11 abort flag", flag[c], 0);
          else begin
            chk(run_len[c] == it.len, "R2 busy length", run_len[c], it.len);
            chk(flag[c] == 1, "R7 flag on done", flag[c], 1);
            chk((c == 0 ? result0 : result1) == it.res, "R9 result",
                c == 0 ? result0 : result1, it.res);
          end
        end
        run_len[c] = 0;
      end
    end
    busy_prev = busy;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++; tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    en = 2'b11;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 0 && flag == 0 && irq == 0, "R1 status", {busy, flag, irq}, 0);
    chk(result0 == 0 && result1 == 0, "R1 results", {result0, result1}, 0);
    chk(tracking == en, "R1 tracking", tracking, en);
    rst_n = 1;
    @(negedge clk);

    // R2 R6: ch0 software start, div 0, no tracking window
    expect_conv(0, 0, 0);
    pulse_sw(2'b01);
    chk(busy[0] && !tracking[0], "R6 no window", {busy[0], tracking[0]}, 2'b10);
    // R10 retrigger while busy ignored
    pulse_sw(2'b01);
    wait_idle();
    // R7 irq follows int_en
    chk(irq[0] == 0, "R7 irq masked", irq[0], 0);
    int_en = 2'b01; #1;
    chk(irq[0] == 1, "R7 irq enabled", irq[0], 1);
    // R8 sticky then cleared
    repeat (5) @(negedge clk);
    chk(flag[0] == 1, "R8 flag sticky", flag[0], 1);
    flag_clr = 2'b01; @(negedge clk); flag_clr = 0;
    chk(flag[0] == 0 && irq[0] == 0, "R8 flag cleared", {flag[0], irq[0]}, 0);
    int_en = 0;

    // R6 tracking window with div 0
    track_mode = 2'b01;
    expect_conv(0, 0, 1);
    @(negedge clk) sw_start = 2'b01;
    @(negedge clk) sw_start = 0;
    chk(busy[0] && tracking[0], "R6 window start", {busy[0], tracking[0]}, 2'b11);
    repeat (2) @(negedge clk);
    chk(tracking[0] == 1, "R6 window last", tracking[0], 1);
    @(negedge clk);
    chk(busy[0] && !tracking[0], "R6 window end", {busy[0], tracking[0]}, 2'b10);
    wait_idle();
    chk(tracking[0] == 1, "R6 idle tracks", tracking[0], 1);

    // R2 divider settings
    track_mode = 0; div0 = 4'd3;
    expect_conv(0, 3, 0);
    pulse_sw(2'b01);
    wait_idle();
    track_mode = 2'b01; div0 = 4'd15;
    expect_conv(0, 15, 1);
    pulse_sw(2'b01);
    wait_idle();
    track_mode = 0; div0 = 4'd1;

    // R3 timer 3 source, other sources ignored
    mode0 = 2'd1;
    pulse_tmr(0); pulse_sw(2'b01);
    chk(busy[0] == 0, "R3 unselected ignored", busy[0], 0);
    expect_conv(0, 1, 0);
    pulse_tmr(1);
    wait_idle();
    // R3 timer 2 source
    mode0 = 2'd3;
    pulse_tmr(1);
    chk(busy[0] == 0, "R3 tmr3 ignored in mode 3", busy[0], 0);
    expect_conv(0, 1, 0);
    pulse_tmr(0);
    wait_idle();

    // R5 external start on ch0 with synchronizer latency
    mode0 = 2'd2;
    expect_conv(0, 1, 0);
    @(negedge clk) ext_start[0] = 1;
    repeat (2) @(negedge clk);
    chk(busy[0] == 0, "R5 sync latency", busy[0], 0);
    @(negedge clk);
    chk(busy[0] == 1, "R5 start after sync", busy[0], 1);
    wait_idle();
    repeat (4) @(negedge clk);
    chk(busy[0] == 0, "R5 held level single start", busy[0], 0);
    ext_start[0] = 0;

    // R4 ch1 slaved to ch0 software start
    mode0 = 2'd1; mode1 = 3'd4; div1 = 4'd2; track_mode = 2'b10;
    expect_conv(1, 2, 1);
    pulse_sw(2'b01);
    chk(busy == 2'b10, "R4 slaved start", busy, 2'b10);
    wait_idle();
    // R4 ch1 own software start in mode 0
    mode1 = 3'd0; track_mode = 0;
    expect_conv(1, 2, 0);
    pulse_sw(2'b10);
    wait_idle();
    // R4 ch1 external pin in mode 2
    mode1 = 3'd2;
    expect_conv(1, 2, 0);
    @(negedge clk) ext_start[1] = 1;
    repeat (3) @(negedge clk);
    chk(busy[1] == 1, "R4 ext1 start", busy[1], 1);
    ext_start[1] = 0;
    wait_idle();
    // R4 reserved select never starts
    mode1 = 3'd5;
    pulse_sw(2'b11); pulse_tmr(1); pulse_tmr(0);
    chk(busy[1] == 0, "R4 reserved select", busy[1], 0);

    // R11 disable aborts a conversion
    flag_clr = 2'b11; @(negedge clk); flag_clr = 0;
    mode0 = 2'd0; div0 = 4'd3;
    expect_abort(0);
    pulse_sw(2'b01);
    repeat (10) @(negedge clk);
    en[0] = 0;
    @(negedge clk);
    chk(busy[0] == 0 && tracking[0] == 0, "R11 disabled idle", {busy[0], tracking[0]}, 0);
    chk(result0 == {1'b0, 15'(done_cnt[0])}, "R11 result kept", result0, {1'b0, 15'(done_cnt[0])});
    pulse_sw(2'b01);
    chk(busy[0] == 0, "R11 disabled ignores start", busy[0], 0);
    en[0] = 1;
    expect_conv(0, 3, 0);
    pulse_sw(2'b01);
    wait_idle();

    repeat (5) @(negedge clk);
    chk(q0.size() == 0 && q1.size() == 0, "R10 scoreboard drained", q0.size() + q1.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule